// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block gives a small multiprocessor system a set of interrupt channels that any processor can use to interrupt others. Every channel keeps a destination mask with one bit per processor and a two-bit configuration word. A processor triggers a channel by writing a bit pattern to the channel's dispatch register. The dispatch register is visible at the same offset in every processor's register window. The written pattern is merged into the mask, and a single edge event is raised on the channel. Each processor named in the mask that is not already holding the channel then gets a one-cycle request strobe.

A processor answers by pulsing its acknowledge strobe with a channel index. This drops its hold on the channel and removes its bit from the channel's mask. If the channel is edge-sensitive and other mask bits are still set, the acknowledge re-raises the channel. Any remaining target that had not yet received it is then reached. Priority arbitration between channels is left to the consumer of the strobes.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, every request strobe is low, every destination mask is empty and every channel is disabled (its disable bit reads as 1), so no dispatch is delivered until the channel is configured.
- R2: An aligned write in the processor window (`wr_global`=0) to offset 0x40 + 16·c ORs `wr_data[NPROC-1:0]` into the mask of channel c. The cycle after the write, `req[p*NCHAN+c]` is high for each processor p whose bit is set and that is not holding channel c.
- R3: Dispatch writes accumulate. A processor already holding the channel gets no second strobe, and only the newly added targets are strobed.
- R4: A dispatch write of value 0 leaves the mask unchanged but still raises the edge event, so mask members that are not holding the channel are strobed.
- R5: While a channel's disable bit (configuration `wr_data[0]`) is 1, it issues no strobes, but dispatch writes still accumulate into its mask.
- R6: An acknowledge (`ack_valid[p]` with channel index in `ack_chan[p*CW +: CW]`) clears processor p's hold and its mask bit for that channel, so later dispatch events no longer reach p.
- R7: When the channel is edge-sensitive (configuration `wr_data[1]`=0) and mask bits remain after an acknowledge, the channel is re-raised. Remaining targets that are not holding it are strobed in the next cycle.
- R8: When the channel is level-sensitive (`wr_data[1]`=1), an acknowledge does not re-raise it.
- R9: Channel c's configuration word is written in the global window (`wr_global`=1) at offset 0x10A0 + 16·c. It takes effect for events from the following cycle on.
- R10: A write whose address has any of its low four bits set is ignored in both windows.
- R11: A request strobe lasts one cycle. The processor cannot be strobed again on that channel until it acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_global | input | 1 | 1 selects the global window, 0 a processor window |
| wr_addr | input | AW | Byte offset within the selected window |
| wr_data | input | DW | Write data |
| ack_valid | input | NPROC | Per-processor acknowledge strobe |
| ack_chan | input | NPROC*CW | Per-processor acknowledged channel index |
| req | output | NPROC*NCHAN | Request strobes, bit p*NCHAN+c for processor p, channel c |

## Verification
The hardest situation to reach from the ports is a re-raise after an acknowledge that actually reaches a waiting target. In normal operation every mask member is strobed at dispatch and is still holding the channel. The stimulus gets around this by dispatching while the channel is disabled, so the targets collect in the mask without being strobed. It then enables the channel and lets one target acknowledge without ever having been strobed. The re-raise then has to strobe the other target. The same disabled-accumulate step, followed by a zero-valued dispatch and a level-sensitive acknowledge, exposes R4 and R8.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NPROC = 4,
  parameter int NCHAN = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] DISP_BASE = 'h40,
  parameter logic [AW-1:0] CFG_BASE = 'h10A0,
  localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_global,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NPROC-1:0]       ack_valid,
  input  logic [NPROC*CW-1:0]    ack_chan,
  output logic [NPROC*NCHAN-1:0] req
);

  localparam logic [AW-5:0] NCH_L = (AW-4)'(NCHAN);

  logic [NCHAN-1:0][NPROC-1:0] mask_q, held_q, mask_n, held_n, ack_m, dlv;
  logic [NCHAN-1:0] dis_q, lvl_q, trig;

  wire            aligned  = (wr_addr[3:0] == 4'd0);
  wire [AW-1:0]   disp_off = wr_addr - DISP_BASE;
  wire [AW-1:0]   cfg_off  = wr_addr - CFG_BASE;
  wire            disp_hit = wr_en && !wr_global && aligned &&
                             (wr_addr >= DISP_BASE) && (disp_off[AW-1:4] < NCH_L);
  wire            cfg_hit  = wr_en && wr_global && aligned &&
                             (wr_addr >= CFG_BASE) && (cfg_off[AW-1:4] < NCH_L);
  wire [CW-1:0]   disp_idx = disp_off[4 +: CW];
  wire [CW-1:0]   cfg_idx  = cfg_off[4 +: CW];

  always_comb begin
    for (int c = 0; c < NCHAN; c++) begin
      for (int p = 0; p < NPROC; p++)
        ack_m[c][p] = ack_valid[p] && (ack_chan[p*CW +: CW] == CW'(c));
      mask_n[c] = (mask_q[c] & ~ack_m[c]) |
                  ((disp_hit && disp_idx == CW'(c)) ? wr_data[NPROC-1:0] : '0);
      trig[c]   = (disp_hit && disp_idx == CW'(c)) ||
                  (!lvl_q[c] && (|ack_m[c]) && (|(mask_q[c] & ~ack_m[c])));
      dlv[c]    = (trig[c] && !dis_q[c]) ? (mask_n[c] & ~(held_q[c] & ~ack_m[c])) : '0;
      held_n[c] = (held_q[c] & ~ack_m[c]) | dlv[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      held_q <= '0;
      dis_q  <= '1;
      lvl_q  <= '0;
      req    <= '0;
    end else begin
      mask_q <= mask_n;
      held_q <= held_n;
      if (cfg_hit) begin
        dis_q[cfg_idx] <= wr_data[0];
        lvl_q[cfg_idx] <= wr_data[1];
      end
      for (int p = 0; p < NPROC; p++)
        for (int c = 0; c < NCHAN; c++)
          req[p*NCHAN + c] <= dlv[c][p];
    end
  end

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int NPROC = 4,
  parameter int NCHAN = 4,
  parameter int AW = 16,
  localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [AW-1:0]               wr_addr,
  input logic [NPROC-1:0]            ack_valid,
  input logic [NPROC*CW-1:0]         ack_chan,
  input logic [NPROC*NCHAN-1:0]      req,
  input logic [NCHAN-1:0][NPROC-1:0] mask_q,
  input logic [NCHAN-1:0]            dis_q,
  input logic [NCHAN-1:0]            lvl_q
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> req == '0);

  a_r10_misaligned_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[3:0] != 4'd0) |=> ($stable(dis_q) && $stable(lvl_q)));

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    logic any_c;
    always_comb begin
      any_c = 1'b0;
      for (int p = 0; p < NPROC; p++) any_c = any_c | req[p*NCHAN + c];
    end

    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[c] |=> !any_c);

    for (genvar p = 0; p < NPROC; p++) begin : g_pr
      wire ah = ack_valid[p] && (ack_chan[p*CW +: CW] == CW'(c));

      a_r2_req_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        req[p*NCHAN + c] |-> mask_q[c][p]);

      a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req[p*NCHAN + c] && !ah) |=> !req[p*NCHAN + c]);
    end
  end

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NPROC(NPROC), .NCHAN(NCHAN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ack_valid(ack_valid), .ack_chan(ack_chan), .req(req),
  .mask_q(mask_q), .dis_q(dis_q), .lvl_q(lvl_q)
);

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb;
  localparam int NP = 4, NC = 4, CWB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_global = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NP-1:0] ack_valid = '0;
  logic [NP*CWB-1:0] ack_chan = '0;
  logic [NP*NC-1:0] req;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_global(wr_global),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_valid(ack_valid),
    .ack_chan(ack_chan), .req(req)
  );

  // behavioural reference
  bit [NP-1:0] m_mask [NC];
  bit [NP-1:0] m_held [NC];
  bit m_dis [NC];
  bit m_lvl [NC];
  bit [NP*NC-1:0] m_req;
  bit [NP-1:0] t_am, t_rem, t_left, t_new;
  bit t_fire, t_disp, t_cfg;
  int t_dch, t_cch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_mask[c] = '0; m_held[c] = '0; m_dis[c] = 1'b1; m_lvl[c] = 1'b0;
      end
      m_req = '0;
    end else begin
      t_disp = wr_en && !wr_global && wr_addr inside {16'h40, 16'h50, 16'h60, 16'h70};
      t_cfg  = wr_en && wr_global && wr_addr inside {16'h10A0, 16'h10B0, 16'h10C0, 16'h10D0};
      t_dch  = (int'(wr_addr) - 'h40) / 16;
      t_cch  = (int'(wr_addr) - 'h10A0) / 16;
      for (int c = 0; c < NC; c++) begin
        t_am = '0;
        for (int p = 0; p < NP; p++)
          if (ack_valid[p] && int'(ack_chan[p*CWB +: CWB]) == c) t_am[p] = 1'b1;
        t_rem  = m_mask[c] & ~t_am;
        t_fire = (t_disp && t_dch == c) || (!m_lvl[c] && t_am != 0 && t_rem != 0);
        if (t_disp && t_dch == c) t_rem = t_rem | wr_data[NP-1:0];
        t_left = m_held[c] & ~t_am;
        t_new  = (t_fire && !m_dis[c]) ? (t_rem & ~t_left) : '0;
        for (int p = 0; p < NP; p++) m_req[p*NC + c] = t_new[p];
        m_mask[c] = t_rem;
        m_held[c] = t_left | t_new;
      end
      if (t_cfg) begin
        m_dis[t_cch] = wr_data[0];
        m_lvl[t_cch] = wr_data[1];
      end
    end
  end

  task automatic chk(input string tag, input logic [NP*NC-1:0] got, input logic [NP*NC-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: req got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) chk("R2 model compare", req, m_req);

  task automatic wr(input bit g, input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_global = g; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_global = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic ack(input int p, input int c);
    ack_valid[p] = 1'b1; ack_chan[p*CWB +: CWB] = CWB'(c);
    @(negedge clk);
    ack_valid = '0; ack_chan = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", req, '0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(0, 16'h40, 32'h0);       chk("R1 disabled after reset", req, '0);
    wr(1, 16'h10A0, 32'h0);     chk("R9 cfg write quiet", req, '0);
    wr(0, 16'h40, 32'h0);       chk("R1 empty mask after reset", req, '0);
    wr(0, 16'h40, 32'h5);       chk("R2 dispatch p0,p2 ch0", req, 16'h0101);
    @(negedge clk);             chk("R11 strobe one cycle", req, '0);
    wr(0, 16'h40, 32'h3);       chk("R3 only new target p1", req, 16'h0010);
    ack(0, 0);                  chk("R6 ack, holders not restrobed", req, '0);
    wr(0, 16'h40, 32'h0);       chk("R6 acked p0 left mask", req, '0);
    wr(0, 16'h50, 32'h3);       chk("R5 disabled ch1 silent", req, '0);
    wr(1, 16'h10B0, 32'h0);     chk("R9 enable ch1", req, '0);
    ack(0, 1);                  chk("R7 re-raise reaches p1 ch1", req, 16'h0020);
    wr(1, 16'h10C0, 32'h3);     chk("R9 ch2 level disabled", req, '0);
    wr(0, 16'h60, 32'h6);       chk("R5 disabled ch2 silent", req, '0);
    wr(1, 16'h10C0, 32'h2);     chk("R9 enable ch2 level", req, '0);
    ack(1, 2);                  chk("R8 level no re-raise", req, '0);
    wr(0, 16'h60, 32'h0);       chk("R4 zero dispatch reaches p2 ch2", req, 16'h0400);
    wr(1, 16'h10D4, 32'h0);     chk("R10 misaligned cfg", req, '0);
    wr(0, 16'h70, 32'h8);       chk("R10 ch3 still disabled", req, '0);
    wr(1, 16'h10D0, 32'h0);     chk("R9 enable ch3", req, '0);
    wr(0, 16'h74, 32'h1);       chk("R10 misaligned dispatch", req, '0);
    wr(0, 16'h70, 32'h0);       chk("R9 ch3 maps to 0x70, p3 only", req, 16'h8000);
    @(negedge clk);             chk("R11 ch3 strobe one cycle", req, '0);
    wr(0, 16'h70, 32'h8);       chk("R11 holder not restrobed", req, '0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule